// File: doc/BRIEF.md
# Variable-Page Translation Lookaside Buffer

This block is a fully associative translation buffer. Every slot holds a virtual page tag, a 13-bit context and a translation word. Each slot carries its own page size, chosen from four, and the page size sets how many virtual address bits the slot compares. Every slot is checked against a 64-bit virtual address in the same cycle. When a slot hits, the block forms the physical address and checks the access against the slot's privilege, write and no-fault attributes. It then reports exactly one outcome: hit, miss, data fault or protection trap.

The block also keeps three registers:
- a fault status register, which can record several fault causes at once;
- a fault address register;
- a tag access register.

A core uses two copies of the block, one for data accesses and one for instruction fetches. Slots are written through a simple indexed fill port. Choosing which slot to replace, and walking the page tables to refill a slot, are left to the logic around the block.

Top module: `vpsz_tlb`

## Requirements
- R1: A slot hits when all three conditions hold. It is valid. It is global, or its stored context equals the lookup context. Its stored virtual tag equals VA[63:13] on every bit kept by the slot's mask. The mask keeps the bits above the page offset. Size codes 0, 1, 2 and 3 select 8 KB, 64 KB, 512 KB and 4 MB pages, which clear 0, 3, 6 and 9 low bits of VA[63:13].
- R2: On a hit, `rsp_pa` takes the slot's physical address on the masked bits and VA on the page-offset bits above bit 12. The result is 41 bits wide and bits 12:0 are zero.
- R3: For data kinds, the lookup context comes from `lk_space`: 0 selects `pri_ctx`, 1 selects `sec_ctx`, and 2 or 3 select context zero (nucleus).
- R4: A fetch (`lk_kind`=3) ignores `lk_space`. It uses `pri_ctx` when `lk_tl_nz`=0 and context zero otherwise.
- R5: When several slots hit, the slot with the lowest index supplies the translation and the attributes.
- R6: A user access (`lk_user`=1) to a privileged slot is a data fault. This applies to fetches too.
- R7: Two more data faults exist, and both apply to data kinds only:
  - A no-fault load (`lk_kind`=2) to a side-effect slot is a data fault.
  - A load or store (`lk_kind`=0 or 1) to a no-fault-only slot is a data fault.
  
  Several fault causes may be present in one access.
- R8: A store (`lk_kind`=1) to a slot without write permission, with no data-fault cause present, raises `rsp_prot` and not `rsp_fault`.
- R9: On a fault or protection trap, `fsr` is rewritten from scratch and `far` takes the full VA. The `fsr` fields are:

  | Bit(s) | Meaning |
  |---|---|
  | 0 | valid |
  | 1 | overwrite, set if bit 0 was already set |
  | 2 | store access |
  | 3 | `lk_priv_mode` |
  | 5:4 | context space: 0 primary, 1 secondary, 2 nucleus. A fetch records 2 when `lk_tl_nz`=1, else 0 |
  | 6 | no-fault load access |
  | 7 | privilege fault |
  | 8 | no-fault load to a side-effect slot |
  | 9 | no-fault-only fault |
- R10: On a miss, a fault or a protection trap, `tag_acc` is loaded with {VA[63:13], lookup context}.
- R11: A miss leaves `fsr` and `far` unchanged.
- R12: Only a clean hit sets the slot's used bit in `used_bits`, and a fill clears it. On a hit, `rsp_wr_ok` gives the slot's write permission and `rsp_bswap` gives its invert-endian bit.
- R13: A lookup presented in one cycle has its response registered at the next clock edge. The response has `rsp_valid` high and exactly one of hit, miss, fault or prot high. After reset all outputs and all slots are zero.
- R14: `fsr_clr` empties `fsr` to zero at the next edge, unless a fault is logged in the same cycle. In that case the fault is recorded as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_en | input | 1 | Write one slot this cycle |
| fill_idx | input | $clog2(ENTRIES) | Slot to write |
| fill_valid | input | 1 | Slot valid |
| fill_global | input | 1 | Slot matches every context |
| fill_size | input | 2 | Page size code |
| fill_priv | input | 1 | Privileged-only slot |
| fill_writable | input | 1 | Write permission |
| fill_nofault_only | input | 1 | Only no-fault loads allowed |
| fill_side_effect | input | 1 | Page has side effects |
| fill_invert_endian | input | 1 | Byte-swap attribute |
| fill_va | input | 64 | Virtual address of the page |
| fill_ctx | input | 13 | Context of the slot |
| fill_pa | input | 41 | Physical address of the page |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 64 | Lookup virtual address |
| lk_kind | input | 2 | 0 load, 1 store, 2 no-fault load, 3 fetch |
| lk_space | input | 2 | 0 primary, 1 secondary, 2/3 nucleus |
| lk_user | input | 1 | User-mode access |
| lk_priv_mode | input | 1 | Processor privileged state, logged in `fsr` |
| lk_tl_nz | input | 1 | Trap level is nonzero |
| pri_ctx | input | 13 | Primary context |
| sec_ctx | input | 13 | Secondary context |
| fsr_clr | input | 1 | Empty the fault status register |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Clean hit |
| rsp_miss | output | 1 | No slot matched |
| rsp_fault | output | 1 | Data fault |
| rsp_prot | output | 1 | Write protection trap |
| rsp_pa | output | 41 | Physical address on a hit |
| rsp_wr_ok | output | 1 | Write permitted on a hit |
| rsp_bswap | output | 1 | Byte-swap flag on a hit |
| used_bits | output | ENTRIES | Per-slot used bits |
| fsr | output | 10 | Fault status register |
| far | output | 64 | Fault address register |
| tag_acc | output | 64 | Tag access register |

## Verification
The bench builds the block with ENTRIES=8, so every slot is written and looked up.

With only eight slots, a sweep runs over all four page sizes and over offsets spread across each page. The sweep also probes the first address just past each page and the last address just before it.

The small slot count also makes overlap easy to set up: a large page can be placed on top of a small one to exercise lowest-index priority.

The fault status state machine is driven through three paths:
- from empty to held;
- from held to held with the overwrite bit;
- back to empty through the clear strobe.

// File: rtl/vpsz_tlb_pkg.sv
package vpsz_tlb_pkg;

    localparam int VA_W    = 64;
    localparam int PA_W    = 41;
    localparam int CTX_W   = 13;
    localparam int PG_SH   = 13;
    localparam int VPN_W   = VA_W - PG_SH;
    localparam int PPN_W   = PA_W - PG_SH;
    localparam int SZ_STEP = 3;
    localparam int FSR_W   = 10;

    // fault status field positions
    localparam int FB_VALID = 0;
    localparam int FB_OVWR  = 1;
    localparam int FB_WRITE = 2;
    localparam int FB_PMODE = 3;
    localparam int FB_CT_LO = 4;
    localparam int FB_NFACC = 6;
    localparam int FB_PRIV  = 7;
    localparam int FB_NFE   = 8;
    localparam int FB_NFO   = 9;

    typedef enum logic [1:0] {
        AK_LOAD   = 2'd0,
        AK_STORE  = 2'd1,
        AK_NFLOAD = 2'd2,
        AK_FETCH  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        CS_PRIMARY   = 2'd0,
        CS_SECONDARY = 2'd1,
        CS_NUCLEUS   = 2'd2,
        CS_ALTNUC    = 2'd3
    } ctx_space_e;

    typedef struct packed {
        logic             valid;
        logic             glob;
        logic [1:0]       size;
        logic             priv;
        logic             wr;
        logic             nfo;
        logic             se;
        logic             ie;
        logic [VPN_W-1:0] vpn;
        logic [CTX_W-1:0] ctx;
        logic [PPN_W-1:0] ppn;
    } tlb_ent_t;

    // keeps the page-number bits above the page offset of a given size
    function automatic logic [VPN_W-1:0] vpn_mask(input logic [1:0] sz);
        logic [VPN_W-1:0] one_v;
        one_v = {{(VPN_W-1){1'b0}}, 1'b1};
        return ~((one_v << (SZ_STEP * int'(sz))) - one_v);
    endfunction

endpackage

// File: rtl/vpsz_tlb_store.sv
module vpsz_tlb_store
    import vpsz_tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  tlb_ent_t          wr_ent,
    input  logic              mark_en,
    input  logic [IDX_W-1:0]  mark_idx,
    output tlb_ent_t          slots [ENTRIES],
    output logic [ENTRIES-1:0] used
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                slots[i] <= '0;
            end
            used <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_en && wr_idx == IDX_W'(i)) begin
                    slots[i] <= wr_ent;
                    used[i]  <= 1'b0;
                end else if (mark_en && mark_idx == IDX_W'(i)) begin
                    used[i]  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/vpsz_tlb_match.sv
module vpsz_tlb_match
    import vpsz_tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  tlb_ent_t          slots [ENTRIES],
    input  logic [VPN_W-1:0]  va_vpn,
    input  logic [CTX_W-1:0]  ctx,
    output logic              any_hit,
    output logic [IDX_W-1:0]  hit_idx,
    output tlb_ent_t          hit_ent
);

    logic [ENTRIES-1:0] hv;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [VPN_W-1:0] m;
        logic             ctx_ok;
        assign m      = vpn_mask(slots[g].size);
        assign ctx_ok = slots[g].glob || (slots[g].ctx == ctx);
        assign hv[g]  = slots[g].valid && ctx_ok &&
                        (((va_vpn ^ slots[g].vpn) & m) == '0);
    end

    // lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        hit_idx = '0;
        hit_ent = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hv[i]) begin
                hit_idx = IDX_W'(i);
                hit_ent = slots[i];
            end
        end
    end

    assign any_hit = |hv;

endmodule

// File: rtl/vpsz_tlb_resolve.sv
module vpsz_tlb_resolve
    import vpsz_tlb_pkg::*;
(
    input  tlb_ent_t         ent,
    input  logic [VPN_W-1:0] va_vpn,
    input  acc_kind_e        kind,
    input  logic             user,
    output logic             f_priv,
    output logic             f_nfe,
    output logic             f_nfo,
    output logic             wr_deny,
    output logic [PA_W-1:0]  pa
);

    logic [VPN_W-1:0] m;
    logic [PPN_W-1:0] ppn;
    logic             is_data;

    assign m       = vpn_mask(ent.size);
    assign is_data = (kind != AK_FETCH);

    assign f_priv  = ent.priv && user;
    assign f_nfe   = is_data && (kind == AK_NFLOAD) && ent.se;
    assign f_nfo   = is_data && (kind != AK_NFLOAD) && ent.nfo;
    assign wr_deny = (kind == AK_STORE) && !ent.wr;

    assign ppn = (ent.ppn & m[PPN_W-1:0]) | (va_vpn[PPN_W-1:0] & ~m[PPN_W-1:0]);
    assign pa  = {ppn, {PG_SH{1'b0}}};

endmodule

// File: rtl/vpsz_tlb_fregs.sv
module vpsz_tlb_fregs
    import vpsz_tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              log_fault,
    input  logic              log_miss,
    input  logic              clr,
    input  logic [FSR_W-1:0]  cause,
    input  logic [VA_W-1:0]   va,
    input  logic [CTX_W-1:0]  ctx,
    output logic [FSR_W-1:0]  fsr,
    output logic [VA_W-1:0]   far,
    output logic [VA_W-1:0]   tag_acc
);

    typedef enum logic {
        FS_EMPTY = 1'b0,
        FS_HELD  = 1'b1
    } fs_state_e;

    fs_state_e st, st_nxt;

    always_comb begin
        st_nxt = st;
        unique case (st)
            FS_EMPTY: if (log_fault) st_nxt = FS_HELD;
            FS_HELD:  if (!log_fault && clr) st_nxt = FS_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= FS_EMPTY;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsr     <= '0;
            far     <= '0;
            tag_acc <= '0;
        end else begin
            if (log_fault) begin
                fsr           <= cause;
                fsr[FB_VALID] <= 1'b1;
                fsr[FB_OVWR]  <= (st == FS_HELD);
                far           <= va;
            end else if (clr) begin
                fsr <= '0;
            end
            if (log_fault || log_miss) begin
                tag_acc <= {va[VA_W-1:PG_SH], ctx};
            end
        end
    end

endmodule

// File: rtl/vpsz_tlb.sv
module vpsz_tlb
    import vpsz_tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_en,
    input  logic [IDX_W-1:0]   fill_idx,
    input  logic               fill_valid,
    input  logic               fill_global,
    input  logic [1:0]         fill_size,
    input  logic               fill_priv,
    input  logic               fill_writable,
    input  logic               fill_nofault_only,
    input  logic               fill_side_effect,
    input  logic               fill_invert_endian,
    input  logic [63:0]        fill_va,
    input  logic [12:0]        fill_ctx,
    input  logic [40:0]        fill_pa,
    input  logic               lk_req,
    input  logic [63:0]        lk_va,
    input  logic [1:0]         lk_kind,
    input  logic [1:0]         lk_space,
    input  logic               lk_user,
    input  logic               lk_priv_mode,
    input  logic               lk_tl_nz,
    input  logic [12:0]        pri_ctx,
    input  logic [12:0]        sec_ctx,
    input  logic               fsr_clr,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic               rsp_miss,
    output logic               rsp_fault,
    output logic               rsp_prot,
    output logic [40:0]        rsp_pa,
    output logic               rsp_wr_ok,
    output logic               rsp_bswap,
    output logic [ENTRIES-1:0] used_bits,
    output logic [9:0]         fsr,
    output logic [63:0]        far,
    output logic [63:0]        tag_acc
);

    acc_kind_e        kind;
    ctx_space_e       space;
    logic [1:0]       ct_code;
    logic [CTX_W-1:0] lk_ctx;
    logic [VPN_W-1:0] va_vpn;

    tlb_ent_t          wr_ent;
    tlb_ent_t          slots [ENTRIES];
    tlb_ent_t          hit_ent;
    logic              any_hit;
    logic [IDX_W-1:0]  hit_idx;
    logic              f_priv, f_nfe, f_nfo, wr_deny;
    logic [PA_W-1:0]   pa;
    logic              is_fault, is_prot, is_ok;
    logic [FSR_W-1:0]  cause;

    assign kind   = acc_kind_e'(lk_kind);
    assign space  = ctx_space_e'(lk_space);
    assign va_vpn = lk_va[VA_W-1:PG_SH];

    // context selection and the space code logged on a fault
    always_comb begin
        if (kind == AK_FETCH) begin
            lk_ctx  = lk_tl_nz ? '0 : pri_ctx;
            ct_code = lk_tl_nz ? 2'd2 : 2'd0;
        end else begin
            unique case (space)
                CS_PRIMARY:   begin lk_ctx = pri_ctx; ct_code = 2'd0; end
                CS_SECONDARY: begin lk_ctx = sec_ctx; ct_code = 2'd1; end
                CS_NUCLEUS,
                CS_ALTNUC:    begin lk_ctx = '0;      ct_code = 2'd2; end
            endcase
        end
    end

    assign wr_ent = '{valid: fill_valid, glob: fill_global, size: fill_size,
                      priv: fill_priv, wr: fill_writable, nfo: fill_nofault_only,
                      se: fill_side_effect, ie: fill_invert_endian,
                      vpn: fill_va[VA_W-1:PG_SH], ctx: fill_ctx,
                      ppn: fill_pa[PA_W-1:PG_SH]};

    vpsz_tlb_store #(.ENTRIES(ENTRIES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (fill_en),
        .wr_idx   (fill_idx),
        .wr_ent   (wr_ent),
        .mark_en  (lk_req && is_ok),
        .mark_idx (hit_idx),
        .slots    (slots),
        .used     (used_bits)
    );

    vpsz_tlb_match #(.ENTRIES(ENTRIES)) u_match (
        .slots   (slots),
        .va_vpn  (va_vpn),
        .ctx     (lk_ctx),
        .any_hit (any_hit),
        .hit_idx (hit_idx),
        .hit_ent (hit_ent)
    );

    vpsz_tlb_resolve u_resolve (
        .ent     (hit_ent),
        .va_vpn  (va_vpn),
        .kind    (kind),
        .user    (lk_user),
        .f_priv  (f_priv),
        .f_nfe   (f_nfe),
        .f_nfo   (f_nfo),
        .wr_deny (wr_deny),
        .pa      (pa)
    );

    assign is_fault = any_hit && (f_priv || f_nfe || f_nfo);
    assign is_prot  = any_hit && !is_fault && wr_deny;
    assign is_ok    = any_hit && !is_fault && !is_prot;

    always_comb begin
        cause = '0;
        cause[FB_WRITE]            = (kind == AK_STORE);
        cause[FB_PMODE]            = lk_priv_mode;
        cause[FB_CT_LO+1:FB_CT_LO] = ct_code;
        cause[FB_NFACC]            = (kind == AK_NFLOAD);
        cause[FB_PRIV]             = f_priv;
        cause[FB_NFE]              = f_nfe;
        cause[FB_NFO]              = f_nfo;
    end

    vpsz_tlb_fregs u_fregs (
        .clk       (clk),
        .rst_n     (rst_n),
        .log_fault (lk_req && (is_fault || is_prot)),
        .log_miss  (lk_req && !any_hit),
        .clr       (fsr_clr),
        .cause     (cause),
        .va        (lk_va),
        .ctx       (lk_ctx),
        .fsr       (fsr),
        .far       (far),
        .tag_acc   (tag_acc)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_prot  <= 1'b0;
            rsp_pa    <= '0;
            rsp_wr_ok <= 1'b0;
            rsp_bswap <= 1'b0;
        end else begin
            rsp_valid <= lk_req;
            rsp_hit   <= lk_req && is_ok;
            rsp_miss  <= lk_req && !any_hit;
            rsp_fault <= lk_req && is_fault;
            rsp_prot  <= lk_req && is_prot;
            rsp_pa    <= (lk_req && is_ok) ? pa : '0;
            rsp_wr_ok <= lk_req && is_ok && hit_ent.wr;
            rsp_bswap <= lk_req && is_ok && hit_ent.ie;
        end
    end

endmodule

// File: rtl/vpsz_tlb_chk.sv
module vpsz_tlb_chk #(
    parameter int ENTRIES = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_req,
    input logic [63:0]        lk_va,
    input logic [1:0]         lk_kind,
    input logic               fsr_clr,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_miss,
    input logic               rsp_fault,
    input logic               rsp_prot,
    input logic [ENTRIES-1:0] used_bits,
    input logic [9:0]         fsr,
    input logic [63:0]        far,
    input logic [63:0]        tag_acc
);

    a_r13_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);

    a_r13_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault, rsp_prot}) == 1);

    a_r9_fault_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault || rsp_prot) |-> fsr[0]);

    a_r9_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        ((rsp_fault || rsp_prot) && $past(fsr[0])) |-> fsr[1]);

    a_r10_tag_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_miss || rsp_fault || rsp_prot) |-> tag_acc[63:13] == $past(lk_va[63:13]));

    a_r11_miss_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_miss && !$past(fsr_clr)) |-> ($stable(fsr) && $stable(far)));

    a_r8_prot_only_store: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_prot |-> $past(lk_kind) == 2'd1);

    a_r12_hit_marks_used: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> used_bits != '0);

endmodule

bind vpsz_tlb vpsz_tlb_chk #(.ENTRIES(ENTRIES)) u_vpsz_tlb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_req    (lk_req),
    .lk_va     (lk_va),
    .lk_kind   (lk_kind),
    .fsr_clr   (fsr_clr),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_fault (rsp_fault),
    .rsp_prot  (rsp_prot),
    .used_bits (used_bits),
    .fsr       (fsr),
    .far       (far),
    .tag_acc   (tag_acc)
);

// File: tb/vpsz_tlb_bench.sv
`timescale 1ns/1ps
module vpsz_tlb_bench;

    localparam int N  = 8;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fill_en = 1'b0;
    logic [IW-1:0] fill_idx = '0;
    logic          fill_valid = 1'b0, fill_global = 1'b0;
    logic [1:0]    fill_size = '0;
    logic          fill_priv = 1'b0, fill_writable = 1'b0, fill_nofault_only = 1'b0;
    logic          fill_side_effect = 1'b0, fill_invert_endian = 1'b0;
    logic [63:0]   fill_va = '0;
    logic [12:0]   fill_ctx = '0;
    logic [40:0]   fill_pa = '0;
    logic          lk_req = 1'b0;
    logic [63:0]   lk_va = '0;
    logic [1:0]    lk_kind = '0, lk_space = '0;
    logic          lk_user = 1'b0, lk_priv_mode = 1'b0, lk_tl_nz = 1'b0;
    logic [12:0]   pri_ctx = 13'd3, sec_ctx = 13'd7;
    logic          fsr_clr = 1'b0;
    logic          rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_prot;
    logic [40:0]   rsp_pa;
    logic          rsp_wr_ok, rsp_bswap;
    logic [N-1:0]  used_bits;
    logic [9:0]    fsr;
    logic [63:0]   far, tag_acc;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    vpsz_tlb #(.ENTRIES(N)) u_vpsz_tlb (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act %h exp %h", tag, act, exp);
        end
    endtask

    // outcome vector {valid, hit, miss, fault, prot}
    task automatic chk_out(input string tag, input logic [4:0] exp);
        chk(tag, 64'({rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_prot}), 64'(exp));
    endtask

    task automatic fill(input int idx, input logic v, input logic g, input logic [1:0] sz,
                        input logic pv, input logic w, input logic nfo, input logic se,
                        input logic ie, input logic [63:0] va, input logic [12:0] cx,
                        input logic [40:0] pa);
        @(negedge clk);
        fill_en = 1'b1; fill_idx = IW'(idx); fill_valid = v; fill_global = g;
        fill_size = sz; fill_priv = pv; fill_writable = w; fill_nofault_only = nfo;
        fill_side_effect = se; fill_invert_endian = ie; fill_va = va; fill_ctx = cx;
        fill_pa = pa;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic look(input logic [63:0] va, input int kind, input int space,
                        input logic user, input logic pm, input logic tl);
        @(negedge clk);
        lk_req = 1'b1; lk_va = va; lk_kind = 2'(kind); lk_space = 2'(space);
        lk_user = user; lk_priv_mode = pm; lk_tl_nz = tl;
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    task automatic do_clr();
        @(negedge clk);
        fsr_clr = 1'b1;
        @(negedge clk);
        fsr_clr = 1'b0;
    endtask

    function automatic logic [63:0] exp_pa(input logic [63:0] pa, input logic [63:0] va,
                                           input int sz);
        logic [63:0] pg;
        pg = 64'd8192 << (3 * sz);
        return ((pa & ~(pg - 1)) | (va & (pg - 1))) & 64'h1FF_FFFF_E000;
    endfunction

    localparam logic [4:0] O_HIT = 5'b11000, O_MISS = 5'b10100,
                           O_FLT = 5'b10010, O_PROT = 5'b10001;
    localparam logic [63:0] PA_X = 64'h0AA_5555_A5A5;

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] va_f, va_s, va_n, va_p, va_i, va_j, va_k, va_q, va_m;
        repeat (3) @(negedge clk);
        // R13: reset state
        chk("R13 reset outcome", 64'({rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_prot}), 0);
        chk("R13 reset fsr", 64'(fsr), 0);
        chk("R13 reset far/tag", far | tag_acc | 64'(used_bits), 0);
        rst_n = 1'b1;

        // R1 R2: sweep over sizes and offsets
        for (int sz = 0; sz < 4; sz++) begin
            automatic logic [63:0] base = 64'h0000_7F00_0000_0000 + 64'(sz) * 64'h0100_0000;
            automatic logic [63:0] pgb  = 64'd8192 << (3 * sz);
            fill(sz, 1, 0, 2'(sz), 0, 1, 0, 0, 0, base, 13'd3, PA_X[40:0]);
            for (int k = 0; k < 8; k++) begin
                automatic logic [63:0] va = base + (pgb / 8) * 64'(k) + 64'h1A8;
                look(va, 0, 0, 0, 0, 0);
                chk("R1 size sweep hit", 64'({rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_prot}), 64'(O_HIT));
                chk("R2 size sweep pa", 64'(rsp_pa), exp_pa(PA_X, va, sz));
            end
            look(base + pgb, 0, 0, 0, 0, 0);
            chk_out("R1 just past page", O_MISS);
            look(base - 64'd1, 0, 0, 0, 0, 0);
            chk_out("R1 just before page", O_MISS);
        end
        chk("R11 misses left fsr empty", 64'(fsr), 0);

        // R6 R9 R10: privilege fault, then overwrite
        va_f = 64'h0000_1234_5678_0000;
        fill(0, 1, 1, 0, 1, 1, 0, 0, 0, va_f, 13'd0, 41'h1_0000_0000);
        look(va_f + 64'h10, 0, 0, 1, 0, 0);
        chk_out("R6 user to priv", O_FLT);
        chk("R9 fsr first fault", 64'(fsr), 64'h081);
        chk("R9 far", far, va_f + 64'h10);
        chk("R10 tag on fault", tag_acc, {va_f[63:13], 13'd3});
        look(va_f, 1, 1, 1, 1, 0);
        chk("R9 fsr overwrite secondary store", 64'(fsr), 64'h09F);
        chk("R10 tag secondary ctx", tag_acc, {va_f[63:13], 13'd7});
        chk("R12 fault leaves used clear", 64'(used_bits[0]), 0);
        do_clr();
        chk("R14 clear empties fsr", 64'(fsr), 0);

        // R8: priv and write-deny together is a fault, not prot
        fill(0, 1, 1, 0, 1, 0, 0, 0, 0, va_f, 13'd0, 41'h1_0000_0000);
        look(va_f, 1, 0, 1, 0, 0);
        chk_out("R8 fault outranks prot", O_FLT);
        do_clr();

        // R7: side-effect and no-fault-only
        va_s = 64'h0000_2000_0000_0000;
        fill(1, 1, 1, 0, 1, 1, 0, 1, 0, va_s, 13'd0, 41'h2_0000_0000);
        look(va_s, 2, 0, 1, 0, 0);
        chk_out("R7 nf load to side effect", O_FLT);
        chk("R7 several causes", 64'(fsr), 64'h1C1);
        do_clr();
        look(va_s, 0, 0, 0, 0, 0);
        chk_out("R7 plain load to side effect hits", O_HIT);
        va_n = 64'h0000_3000_0000_0000;
        fill(2, 1, 1, 0, 0, 1, 1, 0, 0, va_n, 13'd0, 41'h3_0000_0000);
        look(va_n, 0, 0, 0, 0, 0);
        chk("R7 load to nofault-only", 64'(fsr), 64'h201);
        do_clr();
        look(va_n, 2, 0, 0, 0, 0);
        chk_out("R7 nf load to nofault-only hits", O_HIT);

        // R8 R12: protection trap, then hit attributes
        va_p = 64'h0000_4000_0000_0000;
        fill(3, 1, 1, 0, 0, 0, 0, 0, 1, va_p, 13'd0, 41'h4_0000_0000);
        look(va_p, 1, 0, 0, 0, 0);
        chk_out("R8 store to read-only", O_PROT);
        chk("R8 fsr write bit only", 64'(fsr), 64'h005);
        look(va_p, 0, 0, 0, 0, 0);
        chk_out("R12 load hit", O_HIT);
        chk("R12 wr_ok/bswap", 64'({rsp_wr_ok, rsp_bswap}), 64'b01);
        chk("R12 used set", 64'(used_bits[3]), 1);

        // R11: miss keeps fsr and far
        va_m = 64'h0000_5555_0000_0000;
        look(va_m, 0, 0, 0, 0, 0);
        chk_out("R11 miss", O_MISS);
        chk("R11 fsr kept", 64'(fsr), 64'h005);
        chk("R11 far kept", far, va_p);
        chk("R10 tag on miss", tag_acc, {va_m[63:13], 13'd3});
        do_clr();

        // R4: fetch context by trap level
        va_i = 64'h0000_6000_0000_0000;
        fill(4, 1, 0, 0, 0, 1, 0, 0, 0, va_i, 13'd3, 41'h6_0000_0000);
        look(va_i, 3, 1, 0, 0, 0);
        chk_out("R4 fetch tl0 primary", O_HIT);
        look(va_i, 3, 0, 0, 0, 1);
        chk_out("R4 fetch tl1 nucleus miss", O_MISS);
        chk("R4 tag ctx zero", tag_acc, {va_i[63:13], 13'd0});
        va_j = 64'h0000_7000_0000_0000;
        fill(5, 1, 0, 0, 0, 1, 0, 0, 0, va_j, 13'd0, 41'h7_0000_0000);
        look(va_j, 3, 0, 0, 0, 1);
        chk_out("R4 fetch tl1 ctx0 hit", O_HIT);
        va_k = 64'h0000_8000_0000_0000;
        fill(6, 1, 1, 0, 1, 0, 1, 1, 0, va_k, 13'd0, 41'h8_0000_0000);
        look(va_k, 3, 1, 1, 0, 1);
        chk_out("R6 user fetch to priv", O_FLT);
        chk("R9 fetch fsr nucleus", 64'(fsr), 64'h0A1);
        do_clr();

        // R3: data context by space
        look(va_i, 0, 0, 0, 0, 0);
        chk_out("R3 primary match", O_HIT);
        look(va_i, 0, 1, 0, 0, 0);
        chk_out("R3 secondary mismatch", O_MISS);
        sec_ctx = 13'd3;
        look(va_i, 0, 1, 0, 0, 0);
        chk_out("R3 secondary match", O_HIT);
        look(va_i, 0, 2, 0, 0, 0);
        chk_out("R3 nucleus mismatch", O_MISS);
        look(va_j, 0, 3, 0, 0, 0);
        chk_out("R3 nucleus ctx0 match", O_HIT);
        pri_ctx = 13'd99;
        look(va_s, 0, 0, 0, 0, 0);
        chk_out("R1 global ignores ctx", O_HIT);

        // R5: overlapping slots, lowest index wins
        va_q = 64'h0000_9000_0000_0000;
        fill(6, 1, 1, 2, 0, 1, 0, 0, 0, va_q, 13'd0, 41'h0_1230_0000);
        fill(7, 1, 1, 0, 0, 1, 0, 0, 0, va_q + 64'h2000, 13'd0, 41'h0_4560_0000);
        look(va_q + 64'h2000, 0, 0, 0, 0, 0);
        chk("R5 lowest wins", 64'(rsp_pa), exp_pa(64'h0_1230_0000, va_q + 64'h2000, 2));
        chk("R5 used on winner", 64'(used_bits[7:6]), 64'b01);
        fill(6, 0, 1, 2, 0, 1, 0, 0, 0, va_q, 13'd0, 41'h0_1230_0000);
        look(va_q + 64'h2000, 0, 0, 0, 0, 0);
        chk("R5 next slot after invalidate", 64'(rsp_pa), exp_pa(64'h0_4560_0000, va_q, 0));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule